// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits at the issue stage of an out-of-order core. Ready instructions arrive one per cycle, each with an operation class, a sequence number and a tag. They are held in one small ready queue per class, and each queue is kept sorted by sequence number. Every cycle the block compares the heads of all class queues by age. It grants up to `W` of them, oldest first. A class is granted only when a functional unit of that class is free, or when the class needs no unit at all.

A class whose unit is occupied is passed over rather than holding up younger classes, and each such pass-over is counted. A squash request marks every held entry younger than a given sequence number. A marked head is then discarded at the next edge without taking an issue slot. Classes flagged as non-pipelined hold their unit internally for a fixed number of cycles after each grant. All outputs are combinational views of the registered queue state together with the current unit-availability and downstream-ready inputs.

Top module: `issue_picker`

## Requirements
- R1: After reset every class queue is empty, so `iss_vld`, `iss_cnt` and `busy_cnt` are all zero.
- R2: No more than `W` instructions are granted in a cycle, and none is granted while `dn_ready` is low.
- R3: Class heads are considered in increasing order of sequence number. Slot 0 carries the oldest grant and later slots carry younger ones. A class is granted at most once per cycle.
- R4: A kill marks every held entry whose sequence number is greater than `kill_seq`, including an entry inserted in that cycle. At each edge a marked head is removed, whether or not `dn_ready` is high. A marked head is never granted and takes no slot.
- R5: A class with a live head whose unit is unavailable is skipped, and younger classes may still be granted. `busy_cnt` counts such skips only for classes reached before the slots ran out.
- R6: Classes in `NOFU_MASK` are granted without regard to `fu_free`.
- R7: Within a class, entries leave in increasing sequence order. An inserted entry older than the current head becomes the head, and the class takes its new age position in the next cycle.
- R8: A class in `NPIPE_MASK` is unavailable for `ILAT-1` cycles after a grant. Any other class is available in the next cycle whenever `fu_free` is set for it.
- R9: An insertion into a class that already holds `DEPTH` entries is discarded.
- R10: An inserted entry can be granted no earlier than the cycle after its insertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | Insert a ready entry this cycle |
| ins_cls | input | $clog2(NCLS) | Operation class of the inserted entry |
| ins_seq | input | SEQW | Sequence number of the inserted entry |
| ins_tag | input | TAGW | Tag of the inserted entry |
| kill_vld | input | 1 | Squash entries younger than `kill_seq` |
| kill_seq | input | SEQW | Youngest surviving sequence number |
| fu_free | input | NCLS | Per-class unit availability |
| dn_ready | input | 1 | Downstream can accept grants this cycle |
| iss_vld | output | W | Grant valid per slot, slot 0 oldest |
| iss_tag | output | W x TAGW | Tag granted in each slot |
| iss_cls | output | W x $clog2(NCLS) | Class granted in each slot |
| iss_cnt | output | $clog2(W+1) | Number of grants this cycle |
| busy_cnt | output | $clog2(NCLS+1) | Classes skipped for an unavailable unit |

## Verification
Short directed sequences each set up one situation with known ages. These are an older insert that overtakes a head, a busy oldest class ahead of free younger ones, a class that needs no unit while every unit is off, a non-pipelined hold, a full queue and a kill that hits some queue heads. Each sequence separates the age ordering from the width limit. A sweep of all 32 combinations of unit availability and downstream ready over a loaded state distinguishes skipping from stalling. A long pseudo-random run then mixes inserts, kills and availability. Every cycle is compared against an arithmetic model that sorts class heads by age.

// File: rtl/issue_picker.sv
module issue_picker #(
  parameter int NCLS = 4,
  parameter int DEPTH = 4,
  parameter int W = 2,
  parameter int SEQW = 16,
  parameter int TAGW = 8,
  parameter int ILAT = 3,
  parameter logic [NCLS-1:0] NOFU_MASK = 4'b1000,
  parameter logic [NCLS-1:0] NPIPE_MASK = 4'b0100
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ins_vld,
  input  logic [$clog2(NCLS)-1:0]        ins_cls,
  input  logic [SEQW-1:0]                ins_seq,
  input  logic [TAGW-1:0]                ins_tag,
  input  logic                           kill_vld,
  input  logic [SEQW-1:0]                kill_seq,
  input  logic [NCLS-1:0]                fu_free,
  input  logic                           dn_ready,
  output logic [W-1:0]                   iss_vld,
  output logic [W-1:0][TAGW-1:0]         iss_tag,
  output logic [W-1:0][$clog2(NCLS)-1:0] iss_cls,
  output logic [$clog2(W+1)-1:0]         iss_cnt,
  output logic [$clog2(NCLS+1)-1:0]      busy_cnt
);
  localparam int CW = $clog2(NCLS);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(W + 1);
  localparam int BW = $clog2(NCLS + 1);
  localparam int LW = $clog2(ILAT + 1);

  logic [SEQW-1:0]  q_seq [NCLS][DEPTH];
  logic [TAGW-1:0]  q_tag [NCLS][DEPTH];
  logic [DEPTH-1:0] q_sq  [NCLS];
  logic [DW-1:0]    q_cnt [NCLS];
  logic [LW-1:0]    bz    [NCLS];

  logic [SEQW-1:0]  p_seq [NCLS][DEPTH];
  logic [TAGW-1:0]  p_tag [NCLS][DEPTH];
  logic [DEPTH-1:0] p_sq  [NCLS];
  logic [DW-1:0]    p_cnt [NCLS];
  logic [SEQW-1:0]  n_seq [NCLS][DEPTH];
  logic [TAGW-1:0]  n_tag [NCLS][DEPTH];
  logic [DEPTH-1:0] n_sq  [NCLS];
  logic [DW-1:0]    n_cnt [NCLS];

  logic [NCLS-1:0] live, unit_ok, cand, issue, reject, pop;
  logic [BW-1:0]   ahead [NCLS];
  logic [SEQW-1:0] slot_seq [W];

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      live[c]    = (q_cnt[c] != '0) && !q_sq[c][0];
      unit_ok[c] = NOFU_MASK[c] || (fu_free[c] && bz[c] == '0);
    end
  end

  assign cand = live & unit_ok;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      ahead[c] = '0;
      for (int o = 0; o < NCLS; o++) begin
        if (o != c && cand[o] &&
            (q_seq[o][0] < q_seq[c][0] || (q_seq[o][0] == q_seq[c][0] && o < c)))
          ahead[c] = ahead[c] + BW'(1);
      end
      issue[c]  = cand[c] && dn_ready && int'(ahead[c]) < W;
      reject[c] = live[c] && !unit_ok[c] && dn_ready && int'(ahead[c]) < W;
      pop[c]    = issue[c] || (q_cnt[c] != '0 && q_sq[c][0]);
    end
  end

  always_comb begin
    iss_vld  = '0;
    iss_tag  = '0;
    iss_cls  = '0;
    iss_cnt  = '0;
    busy_cnt = '0;
    for (int k = 0; k < W; k++) slot_seq[k] = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (issue[c])  iss_cnt  = iss_cnt + IW'(1);
      if (reject[c]) busy_cnt = busy_cnt + BW'(1);
    end
    for (int k = 0; k < W; k++) begin
      for (int c = 0; c < NCLS; c++) begin
        if (issue[c] && int'(ahead[c]) == k) begin
          iss_vld[k]  = 1'b1;
          iss_tag[k]  = q_tag[c][0];
          iss_cls[k]  = CW'(c);
          slot_seq[k] = q_seq[c][0];
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      p_cnt[c] = q_cnt[c] - DW'(pop[c]);
      p_sq[c]  = q_sq[c];
      for (int j = 0; j < DEPTH; j++) begin
        p_seq[c][j] = q_seq[c][j];
        p_tag[c][j] = q_tag[c][j];
      end
      if (pop[c]) begin
        for (int j = 0; j < DEPTH - 1; j++) begin
          p_seq[c][j] = q_seq[c][j+1];
          p_tag[c][j] = q_tag[c][j+1];
          p_sq[c][j]  = q_sq[c][j+1];
        end
        p_sq[c][DEPTH-1] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      automatic logic hit = ins_vld && ins_cls == CW'(c) && int'(p_cnt[c]) < DEPTH;
      automatic int pos = 0;
      for (int j = 0; j < DEPTH; j++)
        if (j < int'(p_cnt[c]) && p_seq[c][j] < ins_seq) pos++;
      n_sq[c] = p_sq[c];
      for (int j = 0; j < DEPTH; j++) begin
        n_seq[c][j] = p_seq[c][j];
        n_tag[c][j] = p_tag[c][j];
      end
      for (int j = 1; j < DEPTH; j++) begin
        if (hit && j > pos) begin
          n_seq[c][j] = p_seq[c][j-1];
          n_tag[c][j] = p_tag[c][j-1];
          n_sq[c][j]  = p_sq[c][j-1];
        end
      end
      for (int j = 0; j < DEPTH; j++) begin
        if (hit && j == pos) begin
          n_seq[c][j] = ins_seq;
          n_tag[c][j] = ins_tag;
          n_sq[c][j]  = 1'b0;
        end
      end
      n_cnt[c] = p_cnt[c] + DW'(hit);
      for (int j = 0; j < DEPTH; j++) begin
        if (j >= int'(n_cnt[c]))
          n_sq[c][j] = 1'b0;
        else if (kill_vld && n_seq[c][j] > kill_seq)
          n_sq[c][j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCLS; c++) begin
        q_cnt[c] <= '0;
        q_sq[c]  <= '0;
        bz[c]    <= '0;
      end
    end else begin
      q_seq <= n_seq;
      q_tag <= n_tag;
      q_sq  <= n_sq;
      q_cnt <= n_cnt;
      for (int c = 0; c < NCLS; c++) begin
        if (issue[c] && NPIPE_MASK[c])
          bz[c] <= LW'(ILAT - 1);
        else if (bz[c] != '0)
          bz[c] <= bz[c] - LW'(1);
      end
    end
  end

  a_r2_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
    int'(iss_cnt) <= W);
  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_ready |-> iss_cnt == '0 && busy_cnt == '0);

  for (genvar k = 0; k + 1 < W; k++) begin : g_slot
    a_r3_slot_age: assert property (@(posedge clk) disable iff (!rst_n)
      iss_vld[k+1] |-> iss_vld[k] && slot_seq[k] < slot_seq[k+1]);
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    a_r4_marked_head_held: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt[c] != '0 && q_sq[c][0]) |-> !issue[c]);
    a_r9_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_vld && ins_cls == CW'(c) && int'(q_cnt[c]) == DEPTH) |=> int'(q_cnt[c]) <= DEPTH && q_cnt[c] <= $past(q_cnt[c]));
    if (NOFU_MASK[c]) begin : g_nofu
      a_r6_nofu_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (live[c] && dn_ready && int'(ahead[c]) < W) |-> issue[c]);
    end
    if (NPIPE_MASK[c] && ILAT > 1) begin : g_np
      a_r8_npipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        issue[c] |=> !issue[c]);
    end
  end
endmodule

// File: tb/issue_picker_tb_top.sv
module issue_picker_tb_top;
  localparam int NC = 4, DP = 4, WD = 2, IL = 3;
  localparam logic [3:0] NOFU = 4'b1000, NPIPE = 4'b0100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_vld = 1'b0, kill_vld = 1'b0, dn_ready = 1'b0;
  logic [1:0] ins_cls = '0;
  logic [15:0] ins_seq = '0, kill_seq = '0;
  logic [7:0] ins_tag = '0;
  logic [3:0] fu_free = '0;
  logic [WD-1:0] iss_vld;
  logic [WD-1:0][7:0] iss_tag;
  logic [WD-1:0][1:0] iss_cls;
  logic [1:0] iss_cnt;
  logic [2:0] busy_cnt;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int m_seq [NC][DP];
  int m_tag [NC][DP];
  bit m_sq  [NC][DP];
  int m_cnt [NC];
  int m_bz  [NC];
  int seqc = 200;
  int unsigned rs = 32'h1F2E3D4C;

  always #10 clk = ~clk;

  issue_picker #(.NCLS(NC), .DEPTH(DP), .W(WD), .SEQW(16), .TAGW(8), .ILAT(IL),
                 .NOFU_MASK(NOFU), .NPIPE_MASK(NPIPE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_cls(ins_cls), .ins_seq(ins_seq),
    .ins_tag(ins_tag), .kill_vld(kill_vld), .kill_seq(kill_seq), .fu_free(fu_free),
    .dn_ready(dn_ready), .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_cls(iss_cls),
    .iss_cnt(iss_cnt), .busy_cnt(busy_cnt));

  function automatic void chk(string lab, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", lab, act, exp);
    end
  endfunction

  function automatic int tagof(int s);
    return (s * 7 + 3) & 255;
  endfunction

  function automatic int unsigned rnd();
    rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
    return rs;
  endfunction

  task automatic step(string lab, bit iv, int icls, int iseq, bit kv, int kseq,
                      logic [3:0] ff, bit rdy);
    bit vis [NC];
    bit eiss [NC];
    int ev [WD], et [WD], ec [WD];
    int nis = 0, nbz = 0, best, pos;
    ins_vld = iv; ins_cls = icls[1:0]; ins_seq = iseq[15:0]; ins_tag = tagof(iseq);
    kill_vld = kv; kill_seq = kseq[15:0]; fu_free = ff; dn_ready = rdy;
    for (int c = 0; c < NC; c++) begin vis[c] = 0; eiss[c] = 0; end
    for (int k = 0; k < WD; k++) begin ev[k] = 0; et[k] = 0; ec[k] = 0; end
    #1;
    for (int s = 0; s < NC; s++) begin
      best = -1;
      for (int c = 0; c < NC; c++)
        if (!vis[c] && m_cnt[c] > 0 && !m_sq[c][0] &&
            (best < 0 || m_seq[c][0] < m_seq[best][0])) best = c;
      if (best < 0 || !rdy || nis >= WD) break;
      vis[best] = 1;
      if (NOFU[best] || (ff[best] && m_bz[best] == 0)) begin
        ev[nis] = 1; et[nis] = m_tag[best][0]; ec[nis] = best;
        eiss[best] = 1; nis++;
      end else nbz++;
    end
    chk({lab, " iss_cnt"}, int'(iss_cnt), nis);
    chk({lab, " busy_cnt"}, int'(busy_cnt), nbz);
    for (int k = 0; k < WD; k++) begin
      chk({lab, " slot vld"}, int'(iss_vld[k]), ev[k]);
      if (ev[k] != 0) begin
        chk({lab, " slot tag"}, int'(iss_tag[k]), et[k]);
        chk({lab, " slot cls"}, int'(iss_cls[k]), ec[k]);
      end
    end
    @(posedge clk);
    for (int c = 0; c < NC; c++) begin
      if (eiss[c] || (m_cnt[c] > 0 && m_sq[c][0])) begin
        for (int j = 0; j < DP - 1; j++) begin
          m_seq[c][j] = m_seq[c][j+1]; m_tag[c][j] = m_tag[c][j+1]; m_sq[c][j] = m_sq[c][j+1];
        end
        m_cnt[c]--;
      end
      if (eiss[c] && NPIPE[c]) m_bz[c] = IL - 1;
      else if (m_bz[c] > 0) m_bz[c]--;
    end
    if (iv && m_cnt[icls] < DP) begin
      pos = 0;
      for (int j = 0; j < m_cnt[icls]; j++) if (m_seq[icls][j] < iseq) pos++;
      for (int j = m_cnt[icls]; j > pos; j--) begin
        m_seq[icls][j] = m_seq[icls][j-1]; m_tag[icls][j] = m_tag[icls][j-1];
        m_sq[icls][j] = m_sq[icls][j-1];
      end
      m_seq[icls][pos] = iseq; m_tag[icls][pos] = tagof(iseq); m_sq[icls][pos] = 0;
      m_cnt[icls]++;
    end
    if (kv)
      for (int c = 0; c < NC; c++)
        for (int j = 0; j < m_cnt[c]; j++)
          if (m_seq[c][j] > kseq) m_sq[c][j] = 1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin m_cnt[c] = 0; m_bz[c] = 0; end
    repeat (3) @(negedge clk);
    dn_ready = 1'b1; fu_free = 4'hF;
    #1;
    chk("R1 reset iss_cnt", int'(iss_cnt), 0);
    chk("R1 reset busy_cnt", int'(busy_cnt), 0);
    chk("R1 reset iss_vld", int'(iss_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 empty", 0, 0, 0, 0, 0, 4'hF, 1);
    step("R10 insert latency", 1, 0, 40, 0, 0, 4'hF, 1);
    step("R2 stall", 1, 1, 20, 0, 0, 4'hF, 0);
    step("R2 stall", 1, 2, 60, 0, 0, 4'hF, 0);
    step("R2 stall", 1, 3, 50, 0, 0, 4'hF, 0);
    step("R7 older insert", 1, 0, 10, 0, 0, 4'hF, 0);
    step("R3 age order", 0, 0, 0, 0, 0, 4'hF, 1);
    step("R5 busy skip", 0, 0, 0, 0, 0, 4'b1110, 1);
    step("R8 npipe refill", 1, 2, 70, 0, 0, 4'b1110, 1);
    for (int i = 0; i < 3; i++) step("R8 npipe hold", 0, 0, 0, 0, 0, 4'hF, 1);
    step("R6 insert", 1, 3, 80, 0, 0, 4'h0, 0);
    step("R6 no unit needed", 0, 0, 0, 0, 0, 4'h0, 1);
    for (int i = 0; i < 6; i++) step("R9 full drop", 1, 1, 90 + i, 0, 0, 4'hF, 0);
    for (int i = 0; i < 6; i++) step("R9 drain", 0, 0, 0, 0, 0, 4'hF, 1);
    step("R4 setup", 1, 0, 100, 0, 0, 4'hF, 0);
    step("R4 setup", 1, 0, 101, 0, 0, 4'hF, 0);
    step("R4 kill mark", 1, 1, 102, 1, 100, 4'hF, 0);
    for (int i = 0; i < 3; i++) step("R4 marked head", 0, 0, 0, 0, 0, 4'hF, 1);
    for (int p = 0; p < 32; p++) begin
      seqc += 2;
      step("R5 unit sweep", 1, p % NC, seqc, 0, 0, p[3:0], p[4]);
    end
    for (int i = 0; i < 4000; i++) begin
      automatic int unsigned r = rnd();
      automatic bit kv = (r[15:11] == 5'd0);
      seqc += 1 + int'(r[17:16]);
      step("R3 sweep", r[0] | r[1], int'(r[3:2]), seqc, kv, seqc - 1 - int'(r[13:12]),
           r[7:4], r[8] | r[9] | r[10]);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule